// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block carries out the memory traffic a processor core needs when it takes an interrupt or an exception and when it returns from one. It holds the architectural context involved: the code-segment number, the instruction pointer, the stack pointer and the status-flag word. It also holds the base address of a handler table indexed by vector number. When the core asks it to take an event, it saves the context on a downward-growing stack and masks further maskable interrupts. It then reads the handler's start address from the table and loads it into the instruction pointer. A return command pops the saved context back in the reverse order. A separate command sets the interrupt-enable flag again.

All traffic goes through one 32-bit word-wide memory port with a request/ready handshake, so the sequencer works behind a cache or a slow bus. The model is flat: there are no privilege checks, and the segment number is only saved and restored. While a sequence is running, the block reports busy and accepts no command. A one-cycle done pulse marks the end of each entry or return sequence.

Top module: `irq_seq`

## Requirements
- R1: After a synchronous reset, busy, done and mem_req are 0. cur_esp, cur_eip, cur_cs, cur_flags and the table base hold their reset parameter values.
- R2: A take request accepted while idle raises busy on the next cycle. It then writes the flag word, the segment number (zero-extended to 32 bits) and the instruction pointer, in that order. Each write goes to cur_esp minus 4, and cur_esp drops by 4 when each write completes.
- R3: If take_err_vld was 1 when the request was accepted, a fourth write stores take_err_code at the next lower word after the instruction pointer. Otherwise no fourth write happens.
- R4: Flag bit 9 (interrupt enable) is cleared when the last save write completes. The saved flag word carries the value it had before the clear.
- R5: After the saves, one read fetches the word at table base + vector × 8 and loads it into cur_eip. cur_cs is unchanged, and cur_esp ends 12 (no code) or 16 (with code) below its starting value.
- R6: A return command accepted while idle performs three reads at cur_esp, and cur_esp rises by 4 after each one. The first read loads cur_eip, the second loads cur_cs from bits 15:0, and the third loads the whole flag word.
- R7: An enable command accepted while idle sets flag bit 9 on the next cycle. It makes no memory access and raises neither busy nor done.
- R8: Every access keeps mem_req, mem_we, mem_addr and mem_wdata steady until mem_rdy is 1 at a rising edge. The access completes at that edge, and nothing advances while mem_rdy is 0.
- R9: done is high for exactly one cycle: the cycle after the final access of an entry or return sequence completes. busy is 0 in that cycle.
- R10: Take, return and enable commands that arrive while busy is 1 are dropped and have no later effect.
- R11: When several commands arrive in the same idle cycle, take wins over return and return wins over enable. The losers are dropped.
- R12: tbl_base_we loads tbl_base_in into the table base on the next edge. The new base is used by every later descriptor read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| take_req | input | 1 | Take an interrupt or exception (one-cycle pulse) |
| take_vec | input | 8 | Vector number of the event |
| take_err_vld | input | 1 | The event carries an exception code |
| take_err_code | input | 32 | Exception code to save |
| iret_cmd | input | 1 | Return-from-handler command |
| sti_cmd | input | 1 | Set-interrupt-enable command |
| tbl_base_we | input | 1 | Load a new handler-table base |
| tbl_base_in | input | 32 | New handler-table base address |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when a sequence ends |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 32 | Byte address of the word accessed |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, sampled on the edge where mem_rdy is 1 |
| mem_rdy | input | 1 | The current access completes at this edge |
| cur_cs | output | 16 | Code-segment number |
| cur_eip | output | 32 | Instruction pointer |
| cur_esp | output | 32 | Stack pointer |
| cur_flags | output | 32 | Status-flag word, bit 9 is interrupt enable |

## Verification
The properties assume that reset is high from time zero. They also assume that mem_rdy means something only while mem_req is high, and that the table base is rewritten only while the block is idle, so a descriptor read never straddles a base change. The stimulus keeps to this. It writes the base only between sequences and drives mem_rdy either high all the time or from a pseudo-random pattern, so every access sees both stalls and immediate completion. Commands are one-cycle pulses. Some are deliberately fired while busy and some in combination, which exercises the dropping and priority rules without breaking any assumption.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PUSH_FL,
    ST_PUSH_CS,
    ST_PUSH_IP,
    ST_PUSH_EC,
    ST_FETCH,
    ST_POP_IP,
    ST_POP_CS,
    ST_POP_FL
  } seq_st_t;

  function automatic logic st_is_push(seq_st_t s);
    return (s == ST_PUSH_FL) || (s == ST_PUSH_CS) ||
           (s == ST_PUSH_IP) || (s == ST_PUSH_EC);
  endfunction

  function automatic logic st_is_pop(seq_st_t s);
    return (s == ST_POP_IP) || (s == ST_POP_CS) || (s == ST_POP_FL);
  endfunction

  function automatic logic st_is_final(seq_st_t s);
    return (s == ST_FETCH) || (s == ST_POP_FL);
  endfunction

endpackage

// File: rtl/irq_seq_cmd.sv
module irq_seq_cmd #(
  parameter int VEC_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              idle,
  input  logic              take_req,
  input  logic [VEC_W-1:0]  take_vec,
  input  logic              take_err_vld,
  input  logic [DATA_W-1:0] take_err_code,
  input  logic              iret_cmd,
  input  logic              sti_cmd,
  output logic              take_go,
  output logic              iret_go,
  output logic              sti_go,
  output logic [VEC_W-1:0]  vec_q,
  output logic              ec_flag_q,
  output logic [DATA_W-1:0] ec_q
);

  // fixed priority among commands, only while idle
  always_comb begin
    take_go = idle & take_req;
    iret_go = idle & ~take_req & iret_cmd;
    sti_go  = idle & ~take_req & ~iret_cmd & sti_cmd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_q     <= '0;
      ec_flag_q <= 1'b0;
      ec_q      <= '0;
    end else if (take_go) begin
      vec_q     <= take_vec;
      ec_flag_q <= take_err_vld;
      ec_q      <= take_err_code;
    end
  end

endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    take_go,
  input  logic    iret_go,
  input  logic    ec_flag,
  input  logic    xfer,
  output seq_st_t st,
  output logic    done_q
);

  seq_st_t nxt;

  always_comb begin
    nxt = st;
    case (st)
      ST_IDLE: begin
        if (take_go)      nxt = ST_PUSH_FL;
        else if (iret_go) nxt = ST_POP_IP;
      end
      ST_PUSH_FL: if (xfer) nxt = ST_PUSH_CS;
      ST_PUSH_CS: if (xfer) nxt = ST_PUSH_IP;
      ST_PUSH_IP: if (xfer) nxt = ec_flag ? ST_PUSH_EC : ST_FETCH;
      ST_PUSH_EC: if (xfer) nxt = ST_FETCH;
      ST_FETCH:   if (xfer) nxt = ST_IDLE;
      ST_POP_IP:  if (xfer) nxt = ST_POP_CS;
      ST_POP_CS:  if (xfer) nxt = ST_POP_FL;
      ST_POP_FL:  if (xfer) nxt = ST_IDLE;
      default:    nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st     <= nxt;
      done_q <= xfer & st_is_final(st);
    end
  end

endmodule

// File: rtl/irq_seq_ctx.sv
module irq_seq_ctx
  import irq_seq_pkg::*;
#(
  parameter int               ADDR_W     = 32,
  parameter int               DATA_W     = 32,
  parameter int               VEC_W      = 8,
  parameter int               CS_W       = 16,
  parameter int               IF_BIT     = 9,
  parameter int               DESC_SHIFT = 3,
  parameter logic [ADDR_W-1:0] RST_ESP   = 32'h0000_1000,
  parameter logic [ADDR_W-1:0] RST_EIP   = 32'h0000_0100,
  parameter logic [CS_W-1:0]   RST_CS    = 16'h0008,
  parameter logic [DATA_W-1:0] RST_FLAGS = 32'h0000_0202,
  parameter logic [ADDR_W-1:0] RST_BASE  = 32'h0000_8000
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_st_t           st,
  input  logic              xfer,
  input  logic              sti_go,
  input  logic [VEC_W-1:0]  vec_q,
  input  logic              ec_flag_q,
  input  logic [DATA_W-1:0] ec_q,
  input  logic              base_we,
  input  logic [ADDR_W-1:0] base_in,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [DATA_W-1:0] acc_wdata,
  output logic [CS_W-1:0]   cs_q,
  output logic [ADDR_W-1:0] eip_q,
  output logic [ADDR_W-1:0] esp_q,
  output logic [DATA_W-1:0] flags_q
);

  localparam int WORD_BYTES = DATA_W / 8;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  logic [ADDR_W-1:0] base_q;
  logic              last_push;

  assign last_push = (st == ST_PUSH_EC) || ((st == ST_PUSH_IP) && !ec_flag_q);

  // address and write data decoded from registered state only
  always_comb begin
    acc_addr  = '0;
    acc_wdata = '0;
    if (st_is_push(st)) acc_addr = esp_q - STEP;
    else if (st_is_pop(st)) acc_addr = esp_q;
    else if (st == ST_FETCH) acc_addr = base_q + (ADDR_W'(vec_q) << DESC_SHIFT);
    case (st)
      ST_PUSH_FL: acc_wdata = flags_q;
      ST_PUSH_CS: acc_wdata = DATA_W'(cs_q);
      ST_PUSH_IP: acc_wdata = DATA_W'(eip_q);
      ST_PUSH_EC: acc_wdata = ec_q;
      default:    acc_wdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q    <= RST_CS;
      eip_q   <= RST_EIP;
      esp_q   <= RST_ESP;
      flags_q <= RST_FLAGS;
      base_q  <= RST_BASE;
    end else begin
      if (base_we) base_q <= base_in;
      if (sti_go) flags_q[IF_BIT] <= 1'b1;
      if (xfer) begin
        if (st_is_push(st)) begin
          esp_q <= esp_q - STEP;
          if (last_push) flags_q[IF_BIT] <= 1'b0;
        end
        if (st_is_pop(st)) esp_q <= esp_q + STEP;
        case (st)
          ST_FETCH:  eip_q   <= ADDR_W'(rdata);
          ST_POP_IP: eip_q   <= ADDR_W'(rdata);
          ST_POP_CS: cs_q    <= rdata[CS_W-1:0];
          ST_POP_FL: flags_q <= rdata;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_seq_pkg::*;
#(
  parameter int               ADDR_W     = 32,
  parameter int               DATA_W     = 32,
  parameter int               VEC_W      = 8,
  parameter int               CS_W       = 16,
  parameter int               IF_BIT     = 9,
  parameter int               DESC_SHIFT = 3,
  parameter logic [ADDR_W-1:0] RST_ESP   = 32'h0000_1000,
  parameter logic [ADDR_W-1:0] RST_EIP   = 32'h0000_0100,
  parameter logic [CS_W-1:0]   RST_CS    = 16'h0008,
  parameter logic [DATA_W-1:0] RST_FLAGS = 32'h0000_0202,
  parameter logic [ADDR_W-1:0] RST_BASE  = 32'h0000_8000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take_req,
  input  logic [VEC_W-1:0]  take_vec,
  input  logic              take_err_vld,
  input  logic [DATA_W-1:0] take_err_code,
  input  logic              iret_cmd,
  input  logic              sti_cmd,
  input  logic              tbl_base_we,
  input  logic [ADDR_W-1:0] tbl_base_in,
  output logic              busy,
  output logic              done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_rdy,
  output logic [CS_W-1:0]   cur_cs,
  output logic [ADDR_W-1:0] cur_eip,
  output logic [ADDR_W-1:0] cur_esp,
  output logic [DATA_W-1:0] cur_flags
);

  seq_st_t           st;
  logic              idle, xfer;
  logic              take_go, iret_go, sti_go;
  logic [VEC_W-1:0]  vec_q;
  logic              ec_flag_q;
  logic [DATA_W-1:0] ec_q;

  assign idle    = (st == ST_IDLE);
  assign busy    = ~idle;
  assign mem_req = ~idle;
  assign mem_we  = st_is_push(st);
  assign xfer    = mem_req & mem_rdy;

  irq_seq_cmd #(.VEC_W(VEC_W), .DATA_W(DATA_W)) u_cmd (
    .clk(clk), .rst(rst), .idle(idle),
    .take_req(take_req), .take_vec(take_vec),
    .take_err_vld(take_err_vld), .take_err_code(take_err_code),
    .iret_cmd(iret_cmd), .sti_cmd(sti_cmd),
    .take_go(take_go), .iret_go(iret_go), .sti_go(sti_go),
    .vec_q(vec_q), .ec_flag_q(ec_flag_q), .ec_q(ec_q)
  );

  irq_seq_fsm u_fsm (
    .clk(clk), .rst(rst), .take_go(take_go), .iret_go(iret_go),
    .ec_flag(ec_flag_q), .xfer(xfer), .st(st), .done_q(done)
  );

  irq_seq_ctx #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VEC_W(VEC_W), .CS_W(CS_W),
    .IF_BIT(IF_BIT), .DESC_SHIFT(DESC_SHIFT),
    .RST_ESP(RST_ESP), .RST_EIP(RST_EIP), .RST_CS(RST_CS),
    .RST_FLAGS(RST_FLAGS), .RST_BASE(RST_BASE)
  ) u_ctx (
    .clk(clk), .rst(rst), .st(st), .xfer(xfer), .sti_go(sti_go),
    .vec_q(vec_q), .ec_flag_q(ec_flag_q), .ec_q(ec_q),
    .base_we(tbl_base_we), .base_in(tbl_base_in), .rdata(mem_rdata),
    .acc_addr(mem_addr), .acc_wdata(mem_wdata),
    .cs_q(cur_cs), .eip_q(cur_eip), .esp_q(cur_esp), .flags_q(cur_flags)
  );

endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IF_BIT = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              take_req,
  input logic              iret_cmd,
  input logic              sti_cmd,
  input logic              busy,
  input logic              done,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_rdy,
  input logic [ADDR_W-1:0] cur_esp,
  input logic [DATA_W-1:0] cur_flags
);

  // R8: a stalled access holds all of its fields
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_rdy |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R2: a completed save leaves the stack pointer on the slot just written
  assert_push_slot_R2: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we && mem_rdy |=> cur_esp == $past(mem_addr));

  // R4: the read that follows the saves runs with interrupts masked
  assert_fetch_masked_R4: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_we && $past(mem_req && mem_we && mem_rdy) |-> !cur_flags[IF_BIT]);

  // R9: done only while idle, and every end of busy comes with done
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  assert_busy_end_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R7: enable from idle sets the flag without starting a sequence
  assert_sti_R7: assert property (@(posedge clk) disable iff (rst)
    !busy && sti_cmd && !take_req && !iret_cmd |=> cur_flags[IF_BIT] && !busy && !mem_req);

  // R11: a take request from idle wins and starts with a write
  assert_take_first_R11: assert property (@(posedge clk) disable iff (rst)
    !busy && take_req |=> busy && mem_req && mem_we);

endmodule

bind irq_seq irq_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IF_BIT(IF_BIT)) u_chk (
  .clk(clk), .rst(rst), .take_req(take_req), .iret_cmd(iret_cmd), .sti_cmd(sti_cmd),
  .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdy(mem_rdy),
  .cur_esp(cur_esp), .cur_flags(cur_flags)
);

// File: tb/irq_seq_test.sv
module irq_seq_test;

  localparam logic [31:0] R_ESP   = 32'h0000_1000;
  localparam logic [31:0] R_EIP   = 32'h0000_0100;
  localparam logic [15:0] R_CS    = 16'h0008;
  localparam logic [31:0] R_FLAGS = 32'h0000_0202;
  localparam logic [31:0] R_BASE  = 32'h0000_8000;
  localparam logic [31:0] ALT_BASE = 32'h0000_9000;
  localparam int IFB = 9;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        take_req = 0, take_err_vld = 0, iret_cmd = 0, sti_cmd = 0, tbl_base_we = 0;
  logic [7:0]  take_vec = '0;
  logic [31:0] take_err_code = '0, tbl_base_in = '0;
  logic        busy, done, mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, cur_eip, cur_esp, cur_flags;
  logic        mem_rdy;
  logic [15:0] cur_cs;

  always #10 clk = ~clk;

  irq_seq uut (
    .clk(clk), .rst(rst), .take_req(take_req), .take_vec(take_vec),
    .take_err_vld(take_err_vld), .take_err_code(take_err_code),
    .iret_cmd(iret_cmd), .sti_cmd(sti_cmd),
    .tbl_base_we(tbl_base_we), .tbl_base_in(tbl_base_in),
    .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
    .cur_cs(cur_cs), .cur_eip(cur_eip), .cur_esp(cur_esp), .cur_flags(cur_flags)
  );

  // expected access: kind 0 save, 1 last save, 2 table read, 3/4/5 restore eip/cs/flags
  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [2:0]  kind;
  } op_t;

  op_t         q[$];
  logic [31:0] mem [logic [31:0]];
  logic [31:0] m_esp = R_ESP, m_eip = R_EIP, m_flags = R_FLAGS, m_base = R_BASE;
  logic [15:0] m_cs = R_CS;
  bit          m_busy = 0, m_done = 0;
  int          n_chk = 0, n_err = 0;
  string       phase = "R1";
  bit          rdy_rand = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit          finished = 0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h5A00_0000 ^ a;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin : model
    op_t o;
    logic [31:0] e, v;
    bit was_busy;
    if (rst) begin
      m_esp = R_ESP; m_eip = R_EIP; m_cs = R_CS; m_flags = R_FLAGS; m_base = R_BASE;
      m_busy = 0; m_done = 0; q.delete();
    end else begin
      was_busy = m_busy;
      m_done = 0;
      if (tbl_base_we) m_base = tbl_base_in;
      if (was_busy && mem_rdy) begin
        o = q.pop_front();
        v = rd(o.addr);
        case (o.kind)
          3'd0, 3'd1: begin
            mem[o.addr] = o.wdata;
            m_esp = m_esp - 32'd4;
            if (o.kind == 3'd1) m_flags[IFB] = 1'b0;
          end
          3'd2: m_eip = v;
          3'd3: begin m_eip = v; m_esp = m_esp + 32'd4; end
          3'd4: begin m_cs = v[15:0]; m_esp = m_esp + 32'd4; end
          default: begin m_flags = v; m_esp = m_esp + 32'd4; end
        endcase
        if (q.size() == 0) begin m_busy = 0; m_done = 1; end
      end
      if (!was_busy) begin
        e = m_esp;
        if (take_req) begin
          q.push_back('{1'b1, e - 32'd4, m_flags, 3'd0});
          q.push_back('{1'b1, e - 32'd8, {16'h0, m_cs}, 3'd0});
          q.push_back('{1'b1, e - 32'd12, m_eip, take_err_vld ? 3'd0 : 3'd1});
          if (take_err_vld) q.push_back('{1'b1, e - 32'd16, take_err_code, 3'd1});
          q.push_back('{1'b0, m_base + ({24'h0, take_vec} << 3), 32'h0, 3'd2});
          m_busy = 1;
        end else if (iret_cmd) begin
          q.push_back('{1'b0, e, 32'h0, 3'd3});
          q.push_back('{1'b0, e + 32'd4, 32'h0, 3'd4});
          q.push_back('{1'b0, e + 32'd8, 32'h0, 3'd5});
          m_busy = 1;
        end else if (sti_cmd) begin
          m_flags[IFB] = 1'b1;
        end
      end
    end
  end

  // memory responder and ready pattern
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_rdy = rdy_rand ? (lfsr[0] | lfsr[3]) & lfsr[5] : 1'b1;
    mem_rdata = rd(mem_addr);
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin : cmp
    op_t o;
    if (!rst && !finished) begin
      chk(phase, "busy", {31'h0, busy}, {31'h0, m_busy});
      chk(phase, "done R9", {31'h0, done}, {31'h0, m_done});
      chk(phase, "mem_req", {31'h0, mem_req}, {31'h0, m_busy});
      if (m_busy) begin
        o = q[0];
        chk(phase, "mem_we", {31'h0, mem_we}, {31'h0, o.we});
        chk(phase, "mem_addr", mem_addr, o.addr);
        if (o.we) chk(phase, "mem_wdata", mem_wdata, o.wdata);
      end
      chk(phase, "esp", cur_esp, m_esp);
      chk(phase, "eip", cur_eip, m_eip);
      chk(phase, "cs", {16'h0, cur_cs}, {16'h0, m_cs});
      chk(phase, "flags", cur_flags, m_flags);
    end
  end

  task automatic pulse(input bit t, input logic [7:0] vec, input bit ev, input logic [31:0] ec,
                       input bit ir, input bit st);
    @(negedge clk);
    take_req = t; take_vec = vec; take_err_vld = ev; take_err_code = ec;
    iret_cmd = ir; sti_cmd = st;
    @(negedge clk);
    take_req = 0; take_err_vld = 0; iret_cmd = 0; sti_cmd = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (m_busy && n < 500) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    for (int v = 0; v < 32; v++) begin
      mem[R_BASE + 32'(v) * 8]   = 32'hC000_0000 | (32'(v) << 4);
      mem[ALT_BASE + 32'(v) * 8] = 32'hD000_0000 | (32'(v) << 4);
    end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "busy", {31'h0, busy}, 32'h0);
    chk("R1", "mem_req", {31'h0, mem_req}, 32'h0);
    chk("R1", "esp", cur_esp, 32'h0000_1000);
    chk("R1", "flags", cur_flags, 32'h0000_0202);

    // R2 R4 R5 entry without code, ready always
    phase = "R2 R4 R5";
    pulse(1, 8'd5, 0, 32'h0, 0, 0);
    wait_idle();
    chk("R5", "esp after entry", cur_esp, 32'h0000_0FF4);
    chk("R5", "handler eip", cur_eip, 32'hC000_0050);
    chk("R4", "flags masked", cur_flags, 32'h0000_0002);

    // R6 return
    phase = "R6";
    pulse(0, 8'd0, 0, 32'h0, 1, 0);
    wait_idle();
    chk("R6", "esp restored", cur_esp, 32'h0000_1000);
    chk("R6", "eip restored", cur_eip, 32'h0000_0100);
    chk("R6", "cs restored", {16'h0, cur_cs}, 32'h0000_0008);
    chk("R6", "flags restored", cur_flags, 32'h0000_0202);

    // R3 R8 entry with code under stalls, R10 commands while busy
    rdy_rand = 1;
    phase = "R3 R8";
    pulse(1, 8'd14, 1, 32'hABCD_0001, 0, 0);
    phase = "R10";
    pulse(1, 8'd9, 0, 32'h0, 1, 1);
    wait_idle();
    chk("R3", "esp after coded entry", cur_esp, 32'h0000_0FF0);
    chk("R10", "eip not from dropped take", cur_eip, 32'hC000_00E0);
    chk("R10", "flags mask kept", cur_flags[IFB] ? 32'h1 : 32'h0, 32'h0);

    // R7 enable from idle
    phase = "R7";
    pulse(0, 8'd0, 0, 32'h0, 0, 1);
    chk("R7", "flag set", cur_flags[IFB] ? 32'h1 : 32'h0, 32'h1);
    chk("R7", "no sequence", {31'h0, busy}, 32'h0);

    // R11 take beats return and enable
    phase = "R11";
    pulse(1, 8'd3, 0, 32'h0, 1, 1);
    wait_idle();
    chk("R11", "take won", cur_eip, 32'hC000_0030);
    chk("R11", "esp after take", cur_esp, 32'h0000_0FE4);
    pulse(0, 8'd0, 0, 32'h0, 1, 1);
    wait_idle();
    chk("R11", "return won", cur_esp, 32'h0000_0FF0);

    // R12 new table base
    phase = "R12";
    @(negedge clk);
    tbl_base_we = 1; tbl_base_in = ALT_BASE;
    @(negedge clk);
    tbl_base_we = 0;
    pulse(1, 8'd7, 0, 32'h0, 0, 0);
    wait_idle();
    chk("R12", "handler from new base", cur_eip, 32'hD000_0070);

    // R8 R2 R6 mixed traffic with stalls
    phase = "R8 R2 R6";
    for (int i = 0; i < 24; i++) begin
      if ((i % 3) != 2) pulse(1, 8'(i), (i % 2) == 1, 32'h1000_0000 + 32'(i), 0, 0);
      else pulse(0, 8'd0, 0, 32'h0, 1, 0);
      wait_idle();
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule